// File: doc/BRIEF.md
# RTC Periodic Interrupt and Square-Wave Generator

This block derives periodic events from a 32.768 kHz time base. The time base arrives as a one-cycle enable pulse, `tick_en`, in the fast system clock domain. A single power-of-two divider is shared by two consumers:

- a periodic interrupt path, which latches two status flags and raises `irq`;
- a square-wave pin, `sqw`, which toggles every half period.

Each consumer has its own enable bit. A four-bit rate code in a control byte selects the period, and the divider runs only while at least one consumer is enabled.

Software uses a small byte port with four addresses:

| Address | Register |
|---|---|
| 0 | Rate/control byte |
| 1 | Enable byte |
| 2 | Status byte (read-only, cleared when read) |
| 3 | Unused, reads as zero |

Read data is registered and appears one cycle after the read strobe. Reading the status byte returns its contents and then clears the flags, which drops the interrupt line.

Top module: `rtc_pulse_gen`

## Requirements
- R1: After reset, address 0 reads 0x26, address 1 reads 0x02, address 2 reads 0x00, and both `irq` and `sqw` are low.
- R2: When the rate code (bits 3:0 of address 0) is 0, `irq` never rises and `sqw` stays low, whatever the enable bits are.
- R3: Rate codes 1 and 2 act as codes 8 and 9, which gives periods of 128 and 256 time-base ticks.
- R4: For an effective code n from 3 to 15, the period is 2^(n-1) ticks. Only cycles with `tick_en` high advance the divider.
- R5: When bit 6 of address 1 is set, each period end sets bits 7 and 6 of the status byte (value 0xC0), and `irq` is high from the next cycle.
- R6: A read of address 2 returns the flags and clears them, so `irq` goes low. If a period end with bit 6 set falls in the same cycle as the read, the flags are set again, and the read returns the old value.
- R7: When bit 3 of address 1 is set, `sqw` starts low and toggles at every half-period and at every period end. When bit 3 is clear, `sqw` is low.
- R8: The divider runs when the code is nonzero and either bit 6 or bit 3 is set. With only bit 3 set, `sqw` toggles and the status flags stay clear.
- R9: Any write to address 0 restarts the divider from zero and forces `sqw` low. The next event comes a full new period after the write.
- R10: Writes to address 2 and address 3 have no effect. Address 3 reads 0x00.
- R11: `rdata` presents the addressed register one cycle after `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz time-base period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Periodic interrupt, high while the status flags are set |
| sqw | output | 1 | Square-wave output |

## Verification
A divider count that is off by even one shows up as an `irq` rising edge or an `sqw` edge one tick early or late. It is visible at the first period end after a restart, which is at most 16384 ticks away, and within four ticks for code 3. A wrong flag state shows on `irq` in the cycle after the fault, and it shows in `rdata` one cycle after the next status read. A stale phase after a rate write shows on `sqw` within half a period.

// File: rtl/rtc_pulse_pkg.sv
package rtc_pulse_pkg;
  localparam int unsigned PIE_BIT  = 6;
  localparam int unsigned SQWE_BIT = 3;
  localparam logic [7:0]  RST_CTRL_A = 8'h26;
  localparam logic [7:0]  RST_CTRL_B = 8'h02;

  typedef enum logic [1:0] {
    ADDR_CTRL_A = 2'd0,
    ADDR_CTRL_B = 2'd1,
    ADDR_STAT_C = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              period_evt,
  output logic              half_evt
);
  localparam int unsigned NUM_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] lim_tab [NUM_CODES];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] full_last, half_last;
  logic             at_full, at_half, active;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
    localparam int unsigned EC  = (g == 1 || g == 2) ? g + 7 : g;
    localparam int unsigned LIM = (EC == 0) ? 0 : ((1 << (EC - 1)) - 1);
    assign lim_tab[g] = CNT_W'(LIM);
  end

  assign full_last = lim_tab[code];
  assign half_last = full_last >> 1;
  assign active    = run && !restart && tick;
  assign at_full   = (cnt_q == full_last);
  assign at_half   = (cnt_q == half_last);

  always_comb begin
    period_evt = 1'b0;
    half_evt   = 1'b0;
    cnt_d      = cnt_q;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (tick) begin
      if (at_full) begin
        period_evt = 1'b1;
        cnt_d      = '0;
      end else begin
        half_evt = at_half;
        cnt_d    = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= full_last));
  p_evt_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_evt || half_evt) |-> active);
endmodule

// File: rtl/rtc_sqw_drv.sv
module rtc_sqw_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic sq_en,
  input  logic toggle,
  output logic sqw
);
  logic sqw_q, sqw_d;

  always_comb begin
    sqw_d = sqw_q;
    if (!sq_en || !run || restart) sqw_d = 1'b0;
    else if (toggle)               sqw_d = ~sqw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sqw_q <= 1'b0;
    else        sqw_q <= sqw_d;
  end

  assign sqw = sqw_q;

  p_sqw_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_en |=> !sqw_q);
  p_sqw_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sqw_q);
  p_sqw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && run && !restart && !toggle) |=> $stable(sqw_q));
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic       clr,
  output logic [1:0] flags,
  output logic       irq
);
  logic [1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (set)      flags_d = 2'b11;
    else if (clr) flags_d = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 2'b00;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
  assign irq   = flags_q[1];

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> (flags_q == 2'b11));
  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> (flags_q == 2'b00));
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flags_q));
endmodule

// File: rtl/rtc_pulse_gen.sv
module rtc_pulse_gen
  import rtc_pulse_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned DIV_W  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       sqw
);
  localparam int unsigned FLAG_W = 2;

  logic [7:0]        ctrl_a_q, ctrl_a_d, ctrl_b_q, ctrl_b_d, rdata_q, rdata_d;
  logic [CODE_W-1:0] rate_code;
  logic              pie, sqe, run;
  logic              wr_a, wr_b, rd_c;
  logic              period_evt, half_evt;
  logic [FLAG_W-1:0] flags;
  logic [7:0]        stat_c;
  reg_addr_e         addr_e;

  assign addr_e    = reg_addr_e'(addr);
  assign rate_code = ctrl_a_q[CODE_W-1:0];
  assign pie       = ctrl_b_q[PIE_BIT];
  assign sqe       = ctrl_b_q[SQWE_BIT];
  assign run       = (rate_code != '0) && (pie || sqe);
  assign wr_a      = wr_en && (addr_e == ADDR_CTRL_A);
  assign wr_b      = wr_en && (addr_e == ADDR_CTRL_B);
  assign rd_c      = rd_en && (addr_e == ADDR_STAT_C);
  assign stat_c    = {flags, {(8-FLAG_W){1'b0}}};

  rtc_rate_div #(.CODE_W(CODE_W), .CNT_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .run(run), .restart(wr_a),
    .code(rate_code), .period_evt(period_evt), .half_evt(half_evt));

  rtc_sqw_drv u_sqw (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(wr_a), .sq_en(sqe),
    .toggle(period_evt || half_evt), .sqw(sqw));

  rtc_status_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(pie && period_evt), .clr(rd_c),
    .flags(flags), .irq(irq));

  always_comb begin
    ctrl_a_d = wr_a ? wdata : ctrl_a_q;
    ctrl_b_d = wr_b ? wdata : ctrl_b_q;
    rdata_d  = rdata_q;
    if (rd_en) begin
      unique case (addr_e)
        ADDR_CTRL_A: rdata_d = ctrl_a_q;
        ADDR_CTRL_B: rdata_d = ctrl_b_q;
        ADDR_STAT_C: rdata_d = stat_c;
        default:     rdata_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= RST_CTRL_A;
      ctrl_b_q <= RST_CTRL_B;
      rdata_q  <= 8'h00;
    end else begin
      ctrl_a_q <= ctrl_a_d;
      ctrl_b_q <= ctrl_b_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pie));
  p_no_run_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !irq && !rd_c) |=> !irq);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/rtc_pulse_gen_tb.sv
`timescale 1ns/1ps
module rtc_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sqw;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string phase = "init";

  logic [7:0] m_a, m_b, m_c, m_rd;
  logic       m_sqw;
  int         m_cnt;

  rtc_pulse_gen u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sqw(sqw));

  always #2.5 clk = ~clk;

  function automatic int eff_code(int c);
    return (c == 1 || c == 2) ? c + 7 : c;
  endfunction

  function automatic int period_of(int c);
    return 1 << (eff_code(c) - 1);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL [%s] %s %s act=%0h exp=%0h t=%0t", phase, req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int  code, per;
    bit  pie, sqe, run, wr_a, pev, hev;
    code = m_a[3:0];
    pie  = m_b[6];
    sqe  = m_b[3];
    run  = (code != 0) && (pie || sqe);
    wr_a = wr_en && addr == 2'd0;
    per  = (code == 0) ? 1 : period_of(code);
    pev = 0; hev = 0;
    if (!run || wr_a) m_cnt = 0;
    else if (tick_en) begin
      if (m_cnt == per - 1) begin pev = 1; m_cnt = 0; end
      else begin
        if (m_cnt == per / 2 - 1) hev = 1;
        m_cnt++;
      end
    end
    if (!sqe || !run || wr_a) m_sqw = 1'b0;
    else if (pev || hev)       m_sqw = ~m_sqw;
    if (rd_en) begin
      case (addr)
        2'd0: m_rd = m_a;
        2'd1: m_rd = m_b;
        2'd2: m_rd = m_c;
        default: m_rd = 8'h00;
      endcase
    end
    if (pie && pev)                m_c = 8'hC0;
    else if (rd_en && addr == 2'd2) m_c = 8'h00;
    if (wr_en && addr == 2'd0) m_a = wdata;
    if (wr_en && addr == 2'd1) m_b = wdata;
  endtask

  task automatic op(bit w, bit r, logic [1:0] a, logic [7:0] d, bit t);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R5", "irq", irq, m_c[7]);
    chk("R7", "sqw", sqw, m_sqw);
    chk("R11", "rdata", rdata, m_rd);
    wr_en = 0; rd_en = 0; tick_en = 0;
  endtask

  task automatic idle(int n, bit t);
    for (int i = 0; i < n; i++) op(0, 0, 2'd0, 8'h00, t);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_rd = 8'h00; m_sqw = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1 reset";
    chk("R1", "irq", irq, 0);
    chk("R1", "sqw", sqw, 0);
    op(0, 1, 2'd0, 0, 0); chk("R1", "A", rdata, 8'h26);
    op(0, 1, 2'd1, 0, 0); chk("R1", "B", rdata, 8'h02);
    op(0, 1, 2'd2, 0, 0); chk("R1", "C", rdata, 8'h00);
    op(0, 1, 2'd3, 0, 0); chk("R10", "spare", rdata, 8'h00);

    phase = "R2 code0";
    op(1, 0, 2'd1, 8'h4A, 0);
    op(1, 0, 2'd0, 8'h20, 0);
    idle(400, 1);
    chk("R2", "irq idle", irq, 0);
    chk("R2", "sqw idle", sqw, 0);

    phase = "R4 code3";
    op(1, 0, 2'd0, 8'h23, 0);
    idle(3, 1);
    chk("R4", "irq before 4 ticks", irq, 0);
    idle(1, 1);
    chk("R4", "irq at 4 ticks", irq, 1);
    op(0, 1, 2'd2, 0, 0);
    chk("R6", "C read value", rdata, 8'hC0);
    chk("R6", "irq after read", irq, 0);
    idle(2, 0);
    chk("R4", "no tick no event", irq, 0);
    idle(40, 1);
    op(0, 1, 2'd2, 0, 1);

    phase = "R6 same-cycle";
    op(1, 0, 2'd0, 8'h23, 0);
    op(0, 1, 2'd2, 0, 0);
    idle(3, 1);
    op(0, 1, 2'd2, 0, 1);
    chk("R6", "collide irq", irq, 1);

    phase = "R3 alias";
    op(1, 0, 2'd0, 8'h21, 0);
    op(0, 1, 2'd2, 0, 0);
    idle(127, 1);
    chk("R3", "code1 before 128", irq, 0);
    idle(1, 1);
    chk("R3", "code1 at 128", irq, 1);
    op(1, 0, 2'd0, 8'h22, 0);
    op(0, 1, 2'd2, 0, 0);
    idle(255, 1);
    chk("R3", "code2 before 256", irq, 0);
    idle(1, 1);
    chk("R3", "code2 at 256", irq, 1);

    phase = "R8 sqw only";
    op(0, 1, 2'd2, 0, 0);
    op(1, 0, 2'd1, 8'h0A, 0);
    op(1, 0, 2'd0, 8'h24, 0);
    idle(4, 1);
    chk("R8", "sqw high at half", sqw, 1);
    idle(4, 1);
    chk("R8", "sqw low at end", sqw, 0);
    idle(60, 1);
    op(0, 1, 2'd2, 0, 0);
    chk("R8", "no flags", rdata, 8'h00);

    phase = "R9 restart";
    idle(5, 1);
    op(1, 0, 2'd0, 8'h24, 1);
    chk("R9", "sqw low after write", sqw, 0);
    idle(3, 1);
    chk("R9", "sqw still low", sqw, 0);
    idle(1, 1);
    chk("R9", "sqw rises at new half", sqw, 1);

    phase = "R10 ro";
    op(1, 0, 2'd1, 8'h42, 0);
    op(1, 0, 2'd2, 8'hFF, 0);
    op(1, 0, 2'd3, 8'hFF, 0);
    op(0, 1, 2'd2, 0, 0);
    chk("R10", "C after write", rdata, 8'h00);
    op(0, 1, 2'd0, 0, 0);
    chk("R10", "A untouched", rdata, 8'h24);
    op(0, 1, 2'd1, 0, 0);
    chk("R10", "B untouched", rdata, 8'h42);

    phase = "R4 code15";
    op(1, 0, 2'd1, 8'h48, 0);
    op(1, 0, 2'd0, 8'h2F, 0);
    idle(8192, 1);
    chk("R7", "code15 half", sqw, 1);
    idle(8191, 1);
    chk("R4", "code15 before end", irq, 0);
    idle(1, 1);
    chk("R4", "code15 end", irq, 1);

    phase = "random R5 R6 R7 R8 R9";
    for (int i = 0; i < 30000; i++) begin
      int r;
      bit t;
      r = $urandom % 100;
      t = ($urandom % 3) != 0;
      if (r < 2)       op(1, 0, 2'd0, 8'h20 | 8'($urandom % 6), t);
      else if (r < 4)  op(1, 0, 2'd1, (8'($urandom) & 8'h48) | 8'h02, t);
      else if (r < 12) op(0, 1, 2'($urandom), 0, t);
      else             op(0, 0, 2'd0, 0, t);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule